// File: doc/BRIEF.md
# Dual-CPU Doorbell Interrupt Unit

This block lets two processors ring each other through doorbell interrupts. Each processor owns a 4-bit pending-doorbell word. Software reads the word through a status register and changes it through two write-only registers: a write-one-to-set register and a write-one-to-clear register. Bits written as zero change nothing, so a sender can ring its own doorbell bit without disturbing bits that other senders raised. A receiver acknowledges by clearing the bits it has handled. The interrupt line of each processor is a level that stays high while any of its pending bits is set.

Access is through a simple 32-bit APB-style register port that decodes a 4 KB window. A transfer takes effect in the single cycle where `psel` and `penable` are both high. A bank of twelve fixed identification bytes sits at the top of the window and can only be read. Every other offset in the window reads as zero and ignores writes.

Top module: `dbell_unit`

## Requirements
- R1: After reset both pending words are zero, both interrupt lines are low, and both status registers read 0.
- R2: A full-word write to a set register (CPU0 at 0x04, CPU1 at 0x14) ORs bits [3:0] of the written data into that CPU's pending word. Data bits [31:4] are discarded.
- R3: A full-word write to a clear register (CPU0 at 0x08, CPU1 at 0x18) clears the pending bits where bits [3:0] of the data are one. All other pending bits keep their value.
- R4: A read of a status register (CPU0 at 0x00, CPU1 at 0x10) returns the pending word in bits [3:0], with bits [31:4] zero.
- R5: Each interrupt output is high exactly when its pending word is nonzero. It changes at the same clock edge that takes the write.
- R6: Writes to a status register leave both pending words unchanged.
- R7: Reads of the set and clear registers return zero.
- R8: The twelve word offsets 0xFD0 to 0xFFC read, in ascending address order, the bytes 0x04, 0x00, 0x00, 0x00, 0x56, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1, zero-extended to 32 bits. Writes there change nothing.
- R9: Any other offset in the window (for example 0x0C, 0x1C, 0x20, 0x800) reads as zero and ignores writes.
- R10: A write whose byte strobes are not all ones is ignored.
- R11: Address bits [1:0] are not decoded. For example, 0x05 acts as 0x04.
- R12: Writes aimed at one CPU's registers never change the other CPU's pending word or interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase; a transfer occurs when psel and penable are both high |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset within the 4 KB window |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Byte strobes; a write needs all four set |
| prdata | output | 32 | Read data, zero when there is no read |
| irq_cpu0 | output | 1 | Level interrupt to CPU0 |
| irq_cpu1 | output | 1 | Level interrupt to CPU1 |

## Verification
The hardest situation to reach from the ports is a pending word that has been built up by several interleaved set and clear writes, with bits raised and lowered in different calls. It matters because the no-effect-on-zero-bits rule can only fail when unrelated bits are already set. The stimulus reaches it with back-to-back writes that target overlapping and disjoint bit patterns. The data carries upper bits as well, so that any leak through the 4-bit mask shows up. Writes to the other CPU and partial-strobe writes are interleaved with these. A behavioural model checks both interrupt lines on every clock and checks each read as it happens.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

  localparam int NUM_CPU = 2;
  localparam int ID_COUNT = 12;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_SET,
    SEL_CLR,
    SEL_ID
  } sel_e;

  typedef struct packed {
    sel_e       kind;
    logic       cpu;
    logic [3:0] id_idx;
  } dec_t;

  function automatic logic [7:0] id_byte(input logic [3:0] idx);
    logic [7:0] b;
    case (idx)
      4'd0:    b = 8'h04;
      4'd4:    b = 8'h56;
      4'd5:    b = 8'hB8;
      4'd6:    b = 8'h0B;
      4'd8:    b = 8'h0D;
      4'd9:    b = 8'hF0;
      4'd10:   b = 8'h05;
      4'd11:   b = 8'hB1;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
  import dbell_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);

  localparam int WORD_W   = ADDR_W - 2;
  localparam int ID_FIRST = (1 << WORD_W) - ID_COUNT;

  logic [WORD_W-1:0] word;
  logic              unused_addr_lsb;
  logic [WORD_W-1:0] id_off;

  assign word            = addr[ADDR_W-1:2];
  assign unused_addr_lsb = ^addr[1:0];
  assign id_off          = word - WORD_W'(ID_FIRST);

  always_comb begin
    dec        = '0;
    dec.kind   = SEL_NONE;
    if (word[WORD_W-1:3] == '0) begin
      dec.cpu = word[2];
      case (word[1:0])
        2'd0:    dec.kind = SEL_STAT;
        2'd1:    dec.kind = SEL_SET;
        2'd2:    dec.kind = SEL_CLR;
        default: dec.kind = SEL_NONE;
      endcase
    end else if (word >= WORD_W'(ID_FIRST)) begin
      dec.kind   = SEL_ID;
      dec.id_idx = id_off[3:0];
    end
  end

endmodule

// File: rtl/dbell_pend.sv
module dbell_pend #(
  parameter int DB_BITS = 4
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               set_en,
  input  logic               clr_en,
  input  logic [DB_BITS-1:0] wmask,
  output logic [DB_BITS-1:0] pend_o,
  output logic               irq_o
);

  logic [DB_BITS-1:0] pend_q;
  logic [DB_BITS-1:0] pend_d;
  logic               upd;

  always_comb begin
    pend_d = pend_q;
    if (set_en) pend_d = pend_q | wmask;
    if (clr_en) pend_d = pend_q & ~wmask;
  end

  assign upd = set_en | clr_en;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else if (upd) begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = |pend_q;

  a_r2_set_adds: assert property (@(posedge clk) disable iff (!rst_ni)
    set_en |=> ((pend_q & $past(wmask)) == $past(wmask)));

  a_r2_set_keeps: assert property (@(posedge clk) disable iff (!rst_ni)
    set_en |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  a_r3_clr_removes: assert property (@(posedge clk) disable iff (!rst_ni)
    clr_en |=> ((pend_q & $past(wmask)) == '0));

  a_r3_clr_keeps: assert property (@(posedge clk) disable iff (!rst_ni)
    clr_en |=> ((pend_q & ~$past(wmask)) == ($past(pend_q) & ~$past(wmask))));

  a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rst_ni)
    !(set_en || clr_en) |=> $stable(pend_q));

endmodule

// File: rtl/dbell_rdmux.sv
module dbell_rdmux
  import dbell_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DB_BITS = 4
) (
  input  logic               rd_en,
  input  dec_t               dec,
  input  logic [DB_BITS-1:0] pend0,
  input  logic [DB_BITS-1:0] pend1,
  output logic [DATA_W-1:0]  rdata
);

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (dec.kind)
        SEL_STAT: rdata = DATA_W'(dec.cpu ? pend1 : pend0);
        SEL_ID:   rdata = DATA_W'(id_byte(dec.id_idx));
        default:  rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/dbell_unit.sv
module dbell_unit
  import dbell_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int DB_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [3:0]        pstrb,
  output logic [DATA_W-1:0] prdata,
  output logic              irq_cpu0,
  output logic              irq_cpu1
);

  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  dec_t               dec;
  logic               xfer;
  logic               wr_ok;
  logic               rd_en;
  logic               unused_wdata_hi;
  logic [DB_BITS-1:0] pend [NUM_CPU];
  logic [NUM_CPU-1:0] irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n       = rst_sync_q[1];
  assign xfer            = psel & penable;
  assign wr_ok           = xfer & pwrite & (&pstrb);
  assign rd_en           = xfer & ~pwrite;
  assign unused_wdata_hi = ^pwdata[DATA_W-1:DB_BITS];

  dbell_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (paddr),
    .dec  (dec)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic set_en;
    logic clr_en;
    assign set_en = wr_ok && (dec.kind == SEL_SET) && (dec.cpu == 1'(c));
    assign clr_en = wr_ok && (dec.kind == SEL_CLR) && (dec.cpu == 1'(c));

    dbell_pend #(.DB_BITS(DB_BITS)) u_pend (
      .clk    (clk),
      .rst_ni (rst_int_n),
      .set_en (set_en),
      .clr_en (clr_en),
      .wmask  (pwdata[DB_BITS-1:0]),
      .pend_o (pend[c]),
      .irq_o  (irq[c])
    );
  end

  dbell_rdmux #(.DATA_W(DATA_W), .DB_BITS(DB_BITS)) u_rdmux (
    .rd_en (rd_en),
    .dec   (dec),
    .pend0 (pend[0]),
    .pend1 (pend[1]),
    .rdata (prdata)
  );

  assign irq_cpu0 = irq[0];
  assign irq_cpu1 = irq[1];

  a_r7_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_en && (dec.kind == SEL_SET || dec.kind == SEL_CLR)) |-> (prdata == '0));

  a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_en && dec.kind == SEL_NONE) |-> (prdata == '0));

  a_r10_partial_strobe: assert property (@(posedge clk) disable iff (!rst_int_n)
    (xfer && pwrite && !(&pstrb)) |=> ($stable(pend[0]) && $stable(pend[1])));

  a_r6_status_write: assert property (@(posedge clk) disable iff (!rst_int_n)
    (xfer && pwrite && dec.kind == SEL_STAT) |=> ($stable(pend[0]) && $stable(pend[1])));

  a_r4_status_width: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_en && dec.kind == SEL_STAT) |-> (prdata[DATA_W-1:DB_BITS] == '0));

endmodule

// File: tb/tb_dbell_unit.sv
module tb_dbell_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        psel;
  logic        penable;
  logic        pwrite;
  logic [11:0] paddr;
  logic [31:0] pwdata;
  logic [3:0]  pstrb;
  logic [31:0] prdata;
  logic        irq_cpu0;
  logic        irq_cpu1;

  int checks;
  int failures;
  int m_pend [2];
  bit live;
  bit done;
  int id_tbl [12] = '{32'h04, 32'h00, 32'h00, 32'h00, 32'h56, 32'hB8,
                      32'h0B, 32'h00, 32'h0D, 32'hF0, 32'h05, 32'hB1};

  dbell_unit dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .pstrb    (pstrb),
    .prdata   (prdata),
    .irq_cpu0 (irq_cpu0),
    .irq_cpu1 (irq_cpu1)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int model_read(input int addr);
    int w;
    w = (addr >> 2) & 'h3FF;
    if (w == 0) return m_pend[0];
    if (w == 4) return m_pend[1];
    if (w >= 'h3F4) return id_tbl[w - 'h3F4];
    return 0;
  endfunction

  task automatic model_write(input int addr, input int data, input int strb);
    int w;
    int c;
    if (strb != 'hF) return;
    w = (addr >> 2) & 'h3FF;
    if (w < 8) begin
      c = (w >> 2) & 1;
      if ((w & 3) == 1) m_pend[c] = m_pend[c] | (data & 'hF);
      if ((w & 3) == 2) m_pend[c] = m_pend[c] & ~(data & 'hF);
    end
  endtask

  task automatic do_write(input int addr, input int data, input int strb);
    @(negedge clk);
    psel = 1'b1; penable = 1'b1; pwrite = 1'b1;
    paddr = 12'(addr); pwdata = data; pstrb = 4'(strb);
    @(posedge clk);
    model_write(addr, data, strb);
    #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic do_read(input int addr, input string req);
    @(negedge clk);
    psel = 1'b1; penable = 1'b1; pwrite = 1'b0;
    paddr = 12'(addr); pstrb = 4'hF;
    #1;
    check(req, int'(prdata), model_read(addr));
    @(posedge clk);
    #1;
    psel = 1'b0; penable = 1'b0;
  endtask

  // R5 and R12: both interrupt lines follow the model on every clock
  always @(negedge clk) begin
    if (live && !done) begin
      check("R5 irq_cpu0", int'(irq_cpu0), int'(m_pend[0] != 0));
      check("R12 irq_cpu1", int'(irq_cpu1), int'(m_pend[1] != 0));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; live = 0; done = 0;
    m_pend[0] = 0; m_pend[1] = 0;
    rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0; pstrb = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    live = 1;

    // R1: reset state
    do_read('h00, "R1 cpu0 status after reset");
    do_read('h10, "R1 cpu1 status after reset");
    check("R1 irq lines low", int'({irq_cpu1, irq_cpu0}), 0);

    // R2: set with upper garbage bits
    do_write('h04, 'hFFFF_FFF5, 'hF);
    do_read('h00, "R2 R4 cpu0 status after set");
    do_write('h04, 'h0000_0002, 'hF);
    do_read('h00, "R2 set keeps earlier bits");
    do_read('h10, "R12 cpu1 untouched by cpu0 set");

    // R3: clear overlapping bits
    do_write('h08, 'hABCD_0013, 'hF);
    do_read('h00, "R3 clear removes only masked bits");

    // R6: status write ignored
    do_write('h00, 'hF, 'hF);
    do_read('h00, "R6 cpu0 status write ignored");

    // R7: write-only registers read zero
    do_read('h04, "R7 cpu0 set reads zero");
    do_read('h08, "R7 cpu0 clear reads zero");
    do_read('h14, "R7 cpu1 set reads zero");
    do_read('h18, "R7 cpu1 clear reads zero");

    // R12: cpu1 activity, back-to-back writes
    do_write('h14, 'h9, 'hF);
    do_write('h14, 'h6, 'hF);
    do_write('h18, 'h1, 'hF);
    do_read('h10, "R12 cpu1 status");
    do_read('h00, "R12 cpu0 unchanged by cpu1 writes");
    do_write('h10, 'h0, 'hF);
    do_read('h10, "R6 cpu1 status write ignored");

    // R10: partial strobes
    do_write('h04, 'hF, 'h7);
    do_write('h18, 'hF, 'hE);
    do_read('h00, "R10 partial strobe set ignored");
    do_read('h10, "R10 partial strobe clear ignored");

    // R11: low address bits
    do_write('h05, 'h8, 'hF);
    do_read('h03, "R11 unaligned set and status");
    do_write('h1A, 'h2, 'hF);
    do_read('h12, "R11 unaligned clear");

    // R9: unmapped offsets
    do_write('h0C, 'hF, 'hF);
    do_write('h1C, 'hF, 'hF);
    do_write('h800, 'hF, 'hF);
    do_read('h0C, "R9 0x0C reads zero");
    do_read('h20, "R9 0x20 reads zero");
    do_read('h800, "R9 0x800 reads zero");
    do_read('h00, "R9 cpu0 unchanged by unmapped writes");
    do_read('h10, "R9 cpu1 unchanged by unmapped writes");

    // R8: ID bank, and writes there are ignored
    for (int i = 0; i < 12; i++) do_read('hFD0 + 4 * i, "R8 id byte");
    do_write('hFE0, 'hF, 'hF);
    do_read('hFE0, "R8 id write ignored");
    do_read('h00, "R8 cpu0 unchanged by id write");
    do_read('hFCC, "R9 below id bank reads zero");

    // R3 and R5: clear everything, both lines low
    do_write('h08, 'hF, 'hF);
    do_write('h18, 'hFFFF_FFFF, 'hF);
    do_read('h00, "R3 cpu0 cleared");
    do_read('h10, "R3 cpu1 cleared");
    @(negedge clk);
    check("R5 irq lines low after clears", int'({irq_cpu1, irq_cpu0}), 0);

    // R1: reset in mid-operation
    do_write('h04, 'h3, 'hF);
    do_write('h14, 'hC, 'hF);
    live = 0;
    @(negedge clk);
    rst_n = 1'b0;
    m_pend[0] = 0; m_pend[1] = 0;
    #1;
    check("R1 irq low during reset", int'({irq_cpu1, irq_cpu0}), 0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    live = 1;
    do_read('h00, "R1 cpu0 after second reset");
    do_read('h10, "R1 cpu1 after second reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule